// File: doc/BRIEF.md
# Tag-Tracked Reservation Station Pool

This block is a small pool of reservation stations placed in front of one fixed-latency functional unit in an out-of-order core. An instruction enters through the issue stream and lands in the lowest-numbered free station. Each of its two sources arrives either as a ready value or as the tag of the station that will produce it. Allocation never waits for operands. Issue is refused only when every station is occupied.

Each station watches one shared result broadcast made of a valid bit, a tag and a value. A station holding a matching pending tag stores the value and clears the tag. Any number of stations can wake on the same broadcast. A station with both tags clear is sent to the functional unit. When several are ready, the lowest index goes first, one per cycle. The finished result is kept inside its station and offered on an outgoing valid/ready result stream. That stream feeds the bus arbiter. The station frees itself only when the arbiter accepts the result, which is also the cycle in which the arbiter places it on the broadcast bus.

Back-pressure: the issue stream transfers on a clock edge where `issue_valid` and `issue_ready` are both high. `issue_ready` depends only on station occupancy. The result stream transfers where `wb_valid` and `wb_ready` are both high. While `wb_valid` is high and `wb_ready` is low, the offered tag and value stay unchanged.

Top module: `rs_pool`

## Requirements
- R1: Station i (0-based) is named by tag TAG_BASE+i, and tag value 0 means "no pending producer". `issue_tag` shows the tag of the station that the next issue will occupy.
- R2: `issue_ready` is high exactly when at least one station is free, whatever the readiness of the offered operands. An issue transfer occupies the lowest-index free station.
- R3: At issue, a source tag of 0 takes the offered value. A nonzero source tag is left pending, unless the broadcast bus carries that same tag in the same cycle, in which case the broadcast value is taken and nothing is left pending.
- R4: On a broadcast, every waiting station compares the bus tag with both of its pending tags. All stations that match take the value in that same clock edge and clear the matching tag.
- R5: A station with both tags clear is dispatched, with the lowest index first and at most one per cycle, and `dispatch_valid`/`dispatch_tag` show it. A station issued with two ready values is shown in the cycle right after its issue edge.
- R6: The functional unit applies the station's operation code (0 add, 1 subtract a-b, 2 bitwise and, 3 bitwise xor, modulo 2^DATA_W) to source 1 and source 2, and returns the result FU_LAT cycles after dispatch.
- R7: Finished results are offered on the result stream with the lowest-index finished station first. While the offer is not accepted, its tag and value hold.
- R8: A station stays occupied through dispatch and execution, and becomes free on the edge where its result is accepted.
- R9: A broadcast whose tag matches no pending tag changes no station.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| issue_valid | input | 1 | Issue offer present |
| issue_ready | output | 1 | A station is free |
| issue_op | input | 2 | Operation code |
| issue_src1_tag | input | TAG_W | Producer tag of source 1, 0 if ready |
| issue_src1_val | input | DATA_W | Value of source 1 when its tag is 0 |
| issue_src2_tag | input | TAG_W | Producer tag of source 2, 0 if ready |
| issue_src2_val | input | DATA_W | Value of source 2 when its tag is 0 |
| issue_tag | output | TAG_W | Tag given to the next accepted issue |
| cdb_valid | input | 1 | Broadcast present |
| cdb_tag | input | TAG_W | Tag of the broadcasting producer |
| cdb_value | input | DATA_W | Broadcast result value |
| dispatch_valid | output | 1 | A station enters the functional unit this cycle |
| dispatch_tag | output | TAG_W | Tag of the station being dispatched |
| wb_valid | output | 1 | A finished result is offered |
| wb_ready | input | 1 | Arbiter grants the bus to this pool |
| wb_tag | output | TAG_W | Tag of the offered result |
| wb_value | output | DATA_W | Offered result value |

## Verification
The bench builds the pool with four stations, a three-bit tag and a two-cycle unit. Tags 1 to 4 therefore belong to the pool and tags 5 to 7 stand for producers elsewhere. A foreign tag lets every station wait on one producer at once, which makes the full state and the single wake-up reachable, and a second foreign tag acts as a broadcast that matches nothing. All four operation codes are swept over several operand pairs, including subtraction that wraps. The bench itself acts as the bus arbiter, so a result from one station can wake a dependent station in the same pool.

// File: rtl/rs_pool_pkg.sv
package rs_pool_pkg;

  typedef enum logic [1:0] {
    OP_ADD = 2'd0,
    OP_SUB = 2'd1,
    OP_AND = 2'd2,
    OP_XOR = 2'd3
  } alu_op_e;

  typedef enum logic [1:0] {
    SLOT_FREE = 2'd0,
    SLOT_WAIT = 2'd1,
    SLOT_EXEC = 2'd2,
    SLOT_DONE = 2'd3
  } slot_state_e;

endpackage

// File: rtl/rs_pick.sv
module rs_pick #(
  parameter int N     = 4,
  parameter int IDX_W = 2
) (
  input  logic [N-1:0]     req,
  output logic             any,
  output logic [IDX_W-1:0] idx,
  output logic [N-1:0]     grant
);

  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end

  assign any   = |req;
  assign grant = any ? (N'(1) << idx) : '0;

endmodule

// File: rtl/rs_fu_pipe.sv
module rs_fu_pipe
  import rs_pool_pkg::*;
#(
  parameter int LAT    = 2,
  parameter int IDX_W  = 2,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  alu_op_e           in_op,
  input  logic [DATA_W-1:0] in_a,
  input  logic [DATA_W-1:0] in_b,
  input  logic [IDX_W-1:0]  in_idx,
  output logic              out_valid,
  output logic [IDX_W-1:0]  out_idx,
  output logic [DATA_W-1:0] out_result
);

  logic [DATA_W-1:0] alu_y;
  logic              stg_vld [LAT];
  logic [IDX_W-1:0]  stg_idx [LAT];
  logic [DATA_W-1:0] stg_dat [LAT];

  always_comb begin
    unique case (in_op)
      OP_ADD:  alu_y = in_a + in_b;
      OP_SUB:  alu_y = in_a - in_b;
      OP_AND:  alu_y = in_a & in_b;
      default: alu_y = in_a ^ in_b;
    endcase
  end

  for (genvar g = 0; g < LAT; g++) begin : g_stage
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        stg_vld[g] <= 1'b0;
        stg_idx[g] <= '0;
        stg_dat[g] <= '0;
      end else if (g == 0) begin
        stg_vld[g] <= in_valid;
        stg_idx[g] <= in_idx;
        stg_dat[g] <= alu_y;
      end else begin
        stg_vld[g] <= stg_vld[(g == 0) ? 0 : g - 1];
        stg_idx[g] <= stg_idx[(g == 0) ? 0 : g - 1];
        stg_dat[g] <= stg_dat[(g == 0) ? 0 : g - 1];
      end
    end
  end

  assign out_valid  = stg_vld[LAT-1];
  assign out_idx    = stg_idx[LAT-1];
  assign out_result = stg_dat[LAT-1];

endmodule

// File: rtl/rs_entry.sv
module rs_entry
  import rs_pool_pkg::*;
#(
  parameter int TAG_W  = 3,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              alloc,
  input  alu_op_e           alloc_op,
  input  logic [TAG_W-1:0]  alloc_q1,
  input  logic [DATA_W-1:0] alloc_v1,
  input  logic [TAG_W-1:0]  alloc_q2,
  input  logic [DATA_W-1:0] alloc_v2,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  input  logic              start,
  input  logic              fu_done,
  input  logic [DATA_W-1:0] fu_result,
  input  logic              release_i,
  output logic              busy,
  output logic              ready,
  output logic              done,
  output alu_op_e           op_o,
  output logic [DATA_W-1:0] v1_o,
  output logic [DATA_W-1:0] v2_o,
  output logic [DATA_W-1:0] result_o
);

  slot_state_e       state;
  alu_op_e           op_q;
  logic [TAG_W-1:0]  q1, q2;
  logic [DATA_W-1:0] v1, v2, res;

  logic hit_a1, hit_a2, hit_s1, hit_s2;
  assign hit_a1 = cdb_valid && (alloc_q1 != '0) && (cdb_tag == alloc_q1);
  assign hit_a2 = cdb_valid && (alloc_q2 != '0) && (cdb_tag == alloc_q2);
  assign hit_s1 = cdb_valid && (q1 != '0) && (cdb_tag == q1);
  assign hit_s2 = cdb_valid && (q2 != '0) && (cdb_tag == q2);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= SLOT_FREE;
      op_q  <= OP_ADD;
      q1    <= '0;
      q2    <= '0;
      v1    <= '0;
      v2    <= '0;
      res   <= '0;
    end else begin
      unique case (state)
        SLOT_FREE: if (alloc) begin
          state <= SLOT_WAIT;
          op_q  <= alloc_op;
          q1    <= hit_a1 ? '0 : alloc_q1;
          q2    <= hit_a2 ? '0 : alloc_q2;
          v1    <= hit_a1 ? cdb_value : ((alloc_q1 == '0) ? alloc_v1 : '0);
          v2    <= hit_a2 ? cdb_value : ((alloc_q2 == '0) ? alloc_v2 : '0);
        end
        SLOT_WAIT: begin
          if (start) state <= SLOT_EXEC;
          if (hit_s1) begin
            q1 <= '0;
            v1 <= cdb_value;
          end
          if (hit_s2) begin
            q2 <= '0;
            v2 <= cdb_value;
          end
        end
        SLOT_EXEC: if (fu_done) begin
          state <= SLOT_DONE;
          res   <= fu_result;
        end
        default: if (release_i) state <= SLOT_FREE;
      endcase
    end
  end

  assign busy     = (state != SLOT_FREE);
  assign ready    = (state == SLOT_WAIT) && (q1 == '0) && (q2 == '0);
  assign done     = (state == SLOT_DONE);
  assign op_o     = op_q;
  assign v1_o     = v1;
  assign v2_o     = v2;
  assign result_o = res;

  p_snoop_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SLOT_WAIT && hit_s1) |=> (q1 == '0 && v1 == $past(cdb_value)));

  p_exec_stays_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (state == SLOT_EXEC) |=> busy);

  p_done_after_exec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> ($past(state) == SLOT_EXEC && $past(fu_done)));

endmodule

// File: rtl/rs_pool.sv
module rs_pool
  import rs_pool_pkg::*;
#(
  parameter int NUM_RS   = 4,
  parameter int DATA_W   = 16,
  parameter int TAG_W    = 3,
  parameter int TAG_BASE = 1,
  parameter int FU_LAT   = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              issue_valid,
  output logic              issue_ready,
  input  logic [1:0]        issue_op,
  input  logic [TAG_W-1:0]  issue_src1_tag,
  input  logic [DATA_W-1:0] issue_src1_val,
  input  logic [TAG_W-1:0]  issue_src2_tag,
  input  logic [DATA_W-1:0] issue_src2_val,
  output logic [TAG_W-1:0]  issue_tag,
  input  logic              cdb_valid,
  input  logic [TAG_W-1:0]  cdb_tag,
  input  logic [DATA_W-1:0] cdb_value,
  output logic              dispatch_valid,
  output logic [TAG_W-1:0]  dispatch_tag,
  output logic              wb_valid,
  input  logic              wb_ready,
  output logic [TAG_W-1:0]  wb_tag,
  output logic [DATA_W-1:0] wb_value
);

  localparam int IDX_W = (NUM_RS > 1) ? $clog2(NUM_RS) : 1;

  logic [NUM_RS-1:0] busy_vec, free_vec, ready_vec, done_vec;
  logic [NUM_RS-1:0] alloc_gnt, disp_gnt, done_gnt;
  logic [IDX_W-1:0]  alloc_idx, disp_idx, done_idx, wb_idx, wb_idx_q;
  logic              any_free, any_ready, any_done, wb_lock_q;
  alu_op_e           e_op  [NUM_RS];
  logic [DATA_W-1:0] e_v1  [NUM_RS];
  logic [DATA_W-1:0] e_v2  [NUM_RS];
  logic [DATA_W-1:0] e_res [NUM_RS];
  logic              fu_vld;
  logic [IDX_W-1:0]  fu_idx;
  logic [DATA_W-1:0] fu_res;
  logic              issue_fire, wb_fire;

  assign free_vec   = ~busy_vec;
  assign issue_fire = issue_valid && issue_ready;
  assign wb_fire    = wb_valid && wb_ready;

  rs_pick #(.N(NUM_RS), .IDX_W(IDX_W)) u_alloc_pick (
    .req(free_vec), .any(any_free), .idx(alloc_idx), .grant(alloc_gnt));
  rs_pick #(.N(NUM_RS), .IDX_W(IDX_W)) u_disp_pick (
    .req(ready_vec), .any(any_ready), .idx(disp_idx), .grant(disp_gnt));
  rs_pick #(.N(NUM_RS), .IDX_W(IDX_W)) u_done_pick (
    .req(done_vec), .any(any_done), .idx(done_idx), .grant(done_gnt));

  for (genvar i = 0; i < NUM_RS; i++) begin : g_slot
    rs_entry #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_entry (
      .clk       (clk),
      .rst_n     (rst_n),
      .alloc     (issue_fire && alloc_gnt[i]),
      .alloc_op  (alu_op_e'(issue_op)),
      .alloc_q1  (issue_src1_tag),
      .alloc_v1  (issue_src1_val),
      .alloc_q2  (issue_src2_tag),
      .alloc_v2  (issue_src2_val),
      .cdb_valid (cdb_valid),
      .cdb_tag   (cdb_tag),
      .cdb_value (cdb_value),
      .start     (disp_gnt[i]),
      .fu_done   (fu_vld && (fu_idx == IDX_W'(i))),
      .fu_result (fu_res),
      .release_i (wb_fire && (wb_idx == IDX_W'(i))),
      .busy      (busy_vec[i]),
      .ready     (ready_vec[i]),
      .done      (done_vec[i]),
      .op_o      (e_op[i]),
      .v1_o      (e_v1[i]),
      .v2_o      (e_v2[i]),
      .result_o  (e_res[i])
    );
  end

  rs_fu_pipe #(.LAT(FU_LAT), .IDX_W(IDX_W), .DATA_W(DATA_W)) u_fu (
    .clk        (clk),
    .rst_n      (rst_n),
    .in_valid   (any_ready),
    .in_op      (e_op[disp_idx]),
    .in_a       (e_v1[disp_idx]),
    .in_b       (e_v2[disp_idx]),
    .in_idx     (disp_idx),
    .out_valid  (fu_vld),
    .out_idx    (fu_idx),
    .out_result (fu_res)
  );

  // A stalled offer is pinned so a lower station finishing later cannot swap it.
  assign wb_idx   = wb_lock_q ? wb_idx_q : done_idx;
  assign wb_valid = wb_lock_q || any_done;
  assign wb_tag   = TAG_W'(TAG_BASE) + TAG_W'(wb_idx);
  assign wb_value = e_res[wb_idx];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wb_lock_q <= 1'b0;
      wb_idx_q  <= '0;
    end else begin
      wb_lock_q <= wb_valid && !wb_ready;
      wb_idx_q  <= wb_idx;
    end
  end

  assign issue_ready    = any_free;
  assign issue_tag      = TAG_W'(TAG_BASE) + TAG_W'(alloc_idx);
  assign dispatch_valid = any_ready;
  assign dispatch_tag   = TAG_W'(TAG_BASE) + TAG_W'(disp_idx);

  p_wb_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (wb_valid && !wb_ready) |=> (wb_valid && $stable(wb_tag) && $stable(wb_value)));

  p_release_on_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    wb_fire |=> !busy_vec[$past(wb_idx)]);

  p_alloc_takes_slot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    issue_fire |=> busy_vec[$past(alloc_idx)]);

  p_single_dispatch_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(disp_gnt));

endmodule

// File: tb/tb_rs_pool.sv
module tb_rs_pool;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_RS = 4;
  localparam int DATA_W = 16;
  localparam int TAG_W  = 3;
  localparam int FU_LAT = 2;

  logic clk = 1'b0, rst_n = 1'b0;
  logic issue_valid = 1'b0, issue_ready;
  logic [1:0] issue_op = '0;
  logic [TAG_W-1:0] issue_src1_tag = '0, issue_src2_tag = '0, issue_tag;
  logic [DATA_W-1:0] issue_src1_val = '0, issue_src2_val = '0;
  logic cdb_valid = 1'b0;
  logic [TAG_W-1:0] cdb_tag = '0;
  logic [DATA_W-1:0] cdb_value = '0;
  logic dispatch_valid, wb_valid, wb_ready = 1'b0;
  logic [TAG_W-1:0] dispatch_tag, wb_tag;
  logic [DATA_W-1:0] wb_value;

  int checks = 0, failures = 0;

  rs_pool #(.NUM_RS(NUM_RS), .DATA_W(DATA_W), .TAG_W(TAG_W), .TAG_BASE(1), .FU_LAT(FU_LAT)) dut (
    .clk(clk), .rst_n(rst_n), .issue_valid(issue_valid), .issue_ready(issue_ready),
    .issue_op(issue_op), .issue_src1_tag(issue_src1_tag), .issue_src1_val(issue_src1_val),
    .issue_src2_tag(issue_src2_tag), .issue_src2_val(issue_src2_val), .issue_tag(issue_tag),
    .cdb_valid(cdb_valid), .cdb_tag(cdb_tag), .cdb_value(cdb_value),
    .dispatch_valid(dispatch_valid), .dispatch_tag(dispatch_tag),
    .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_tag(wb_tag), .wb_value(wb_value));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  function automatic int alu_ref(input int op, input int a, input int b);
    int y;
    case (op)
      0: y = a + b;
      1: y = a - b;
      2: y = a & b;
      default: y = a ^ b;
    endcase
    return y & 16'hFFFF;
  endfunction

  // Called at a negedge; returns at the negedge after the issue edge.
  task automatic do_issue(input int op, input int t1, input int v1, input int t2, input int v2,
                          output int got);
    issue_valid = 1'b1;
    issue_op = op[1:0];
    issue_src1_tag = t1[TAG_W-1:0];
    issue_src1_val = v1[DATA_W-1:0];
    issue_src2_tag = t2[TAG_W-1:0];
    issue_src2_val = v2[DATA_W-1:0];
    got = int'(issue_tag);
    @(posedge clk);
    @(negedge clk);
    issue_valid = 1'b0;
    cdb_valid = 1'b0;
  endtask

  task automatic broadcast(input int t, input int v);
    cdb_valid = 1'b1;
    cdb_tag = t[TAG_W-1:0];
    cdb_value = v[DATA_W-1:0];
    @(posedge clk);
    @(negedge clk);
    cdb_valid = 1'b0;
  endtask

  // Acts as the bus arbiter: grants the offered result and broadcasts it.
  task automatic take_wb(input string req, input int exp_tag, input int exp_val);
    for (int n = 0; n < 20 && !wb_valid; n++) @(negedge clk);
    check(req, "wb_valid", int'(wb_valid), 1);
    check(req, "wb_tag", int'(wb_tag), exp_tag);
    check(req, "wb_value", int'(wb_value), exp_val);
    wb_ready = 1'b1;
    cdb_valid = 1'b1;
    cdb_tag = wb_tag;
    cdb_value = wb_value;
    @(posedge clk);
    @(negedge clk);
    wb_ready = 1'b0;
    cdb_valid = 1'b0;
  endtask

  task automatic finish_run();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int got, a, b, x;
    int imm [4];
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // Reset state (R1, R2)
    check("R2", "reset issue_ready", int'(issue_ready), 1);
    check("R1", "reset issue_tag", int'(issue_tag), 1);
    check("R5", "reset dispatch_valid", int'(dispatch_valid), 0);
    check("R7", "reset wb_valid", int'(wb_valid), 0);

    // Fill all stations waiting on foreign tag 5 (R1, R2, R3)
    for (int i = 0; i < NUM_RS; i++) begin
      imm[i] = (i + 1) * 16'h1111;
      check("R2", "ready while filling", int'(issue_ready), 1);
      do_issue(i, 5, 16'hDEAD, 0, imm[i], got);
      check("R1", "allocated tag", got, i + 1);
    end
    check("R2", "full stalls issue", int'(issue_ready), 0);
    check("R3", "pending source not dispatched", int'(dispatch_valid), 0);

    // Non-matching broadcast has no effect (R9)
    broadcast(6, 16'h5555);
    check("R9", "no wake on foreign tag", int'(dispatch_valid), 0);
    @(negedge clk);
    check("R9", "still no dispatch", int'(dispatch_valid), 0);

    // One broadcast wakes every waiter; dispatch in index order (R4, R5)
    x = 16'hABCD;
    broadcast(5, x);
    for (int i = 0; i < NUM_RS; i++) begin
      check("R4", "dispatch_valid after wake", int'(dispatch_valid), 1);
      check("R5", "dispatch order", int'(dispatch_tag), i + 1);
      @(negedge clk);
    end
    check("R5", "all dispatched", int'(dispatch_valid), 0);

    // Results held under back-pressure (R7, R8)
    repeat (FU_LAT + 2) @(negedge clk);
    for (int n = 0; n < 6; n++) begin
      check("R7", "held wb_valid", int'(wb_valid), 1);
      check("R7", "held wb_tag", int'(wb_tag), 1);
      check("R7", "held wb_value", int'(wb_value), alu_ref(0, x, imm[0]));
      @(negedge clk);
    end
    check("R8", "busy after execute", int'(issue_ready), 0);
    take_wb("R7", 1, alu_ref(0, x, imm[0]));
    check("R8", "freed on accept", int'(issue_ready), 1);
    check("R8", "freed slot is next", int'(issue_tag), 1);
    for (int i = 1; i < NUM_RS; i++) take_wb("R6", i + 1, alu_ref(i, x, imm[i]));
    check("R8", "all free tag", int'(issue_tag), 1);

    // Operation sweep with ready operands (R5, R6)
    for (int op = 0; op < 4; op++) begin
      for (int k = 0; k < 6; k++) begin
        a = ((k * 16'h3A7) + (op * 16'h91) + (k << 12)) & 16'hFFFF;
        b = ((k * 16'h1F3) + 16'h0F0F * (k & 1) + 1) & 16'hFFFF;
        do_issue(op, 0, a, 0, b, got);
        check("R5", "next-cycle dispatch", int'(dispatch_valid), 1);
        check("R5", "dispatch tag", int'(dispatch_tag), 1);
        take_wb("R6", 1, alu_ref(op, a, b));
      end
    end

    // Same-cycle capture at issue (R3)
    cdb_valid = 1'b1;
    cdb_tag = 3'd6;
    cdb_value = 16'h1234;
    do_issue(1, 6, 0, 0, 16'h0034, got);
    check("R3", "issue-time capture dispatch", int'(dispatch_valid), 1);
    take_wb("R3", 1, 16'h1200);

    // Dependency on a pool result through the bus (R4)
    do_issue(0, 0, 10, 0, 20, got);
    do_issue(1, 1, 0, 0, 5, got);
    check("R1", "dependent tag", got, 2);
    take_wb("R4", 1, 30);
    check("R4", "dependent woken", int'(dispatch_valid), 1);
    check("R4", "dependent tag dispatched", int'(dispatch_tag), 2);
    take_wb("R4", 2, 25);

    finish_run();
  end
endmodule